// File: doc/BRIEF.md
# Reset-Time Boot Source Selector

This block runs once after reset and decides where a processor fetches its first program. It samples a mode strap that picks between running straight from external memory and running the on-chip boot sequence. For the on-chip sequence it lowers a host-interrupt output. It then weighs two active-low request inputs in a fixed order and settles on host-port boot, serial boot or parallel boot. Serial and parallel loading are done elsewhere. This block only reports the chosen mode, the boot vector and a one-cycle start pulse.

Host-port boot has one more step. The block wipes two mailbox words in a small dual-access RAM. A host writes into that RAM through its own port. The block reads the entry word (address 7Fh) every few cycles until it holds a nonzero value. It then loads the program counter from that word and the page register from the page word (address 7Eh), and pulses start. All three mode inputs pass through a two-stage synchronizer before the block uses them.

Top module: `boot_src_fsm`

## Requirements
- R1: While reset is held, `hint_n` is 1, `boot_go` is 0, `boot_mode` is 2'b00 and `boot_pc` is 0000h.
- R2: The mode inputs are read only after two synchronizer stages. The strap decision therefore takes effect at the 3rd rising edge after reset is released.
- R3: If the synchronized strap is 1, the block reports external mode (`boot_mode` = 2'b00) with `boot_pc` = EXT_ENTRY (default 0100h). It pulses `boot_go` at the 3rd edge and keeps `hint_n` at 1. The two request inputs are ignored.
- R4: If the strap is 0, `hint_n` goes low at the 3rd edge and stays low. `boot_pc` shows the on-chip vector FF80h from that edge on.
- R5: At the 4th edge the request inputs are weighed. A low `int2_n` selects host-port mode 2'b01 whatever `int3_n` is. Otherwise a low `int3_n` selects serial mode 2'b10. Otherwise parallel mode 2'b11 is selected. Serial and parallel mode pulse `boot_go` at that same edge with `boot_pc` = FF80h.
- R6: In host-port mode, mailbox words 7Eh and 7Fh are cleared once the mode is chosen. Values a host wrote into them earlier never release the boot.
- R7: `boot_go` does not rise in host-port mode while word 7Fh is zero. A nonzero page word 7Eh alone does not release it.
- R8: Once word 7Fh holds a nonzero value, `boot_go` pulses within 3 to POLL_N+6 cycles of the write. At that pulse `boot_pc` equals word 7Fh (all 16 bits), `boot_xpc` equals the low XPC_W bits of word 7Eh, and `boot_mode` is 2'b01.
- R9: `boot_go` is high for exactly one cycle per reset. `boot_mode`, `boot_pc`, `boot_xpc` and `hint_n` then hold their values until the next reset.
- R10: Two successive local reads of word 7Fh are at least POLL_N cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ext | input | 1 | Mode strap: 1 = run from external memory, 0 = on-chip boot |
| int2_n | input | 1 | Active-low request that selects host-port boot (highest priority) |
| int3_n | input | 1 | Active-low request that selects serial boot |
| host_we | input | 1 | Host write strobe into the mailbox RAM |
| host_addr | input | AW | Host write word address |
| host_wdata | input | DW | Host write data |
| hint_n | output | 1 | Host-interrupt output, driven low once on-chip boot is entered |
| boot_mode | output | 2 | 00 external, 01 host-port, 10 serial, 11 parallel |
| boot_pc | output | DW | Program counter / jump target |
| boot_xpc | output | XPC_W | Extended page value |
| boot_go | output | 1 | One-cycle start pulse |

## Verification
External mode results are due at the 3rd rising edge after reset release. Serial and parallel results are due at the 4th edge. The bench counts edges from the release and samples each result on the falling edge that follows the edge where it is due. In host-port mode the start pulse comes from a polling window and cannot be fixed to one cycle. The bench therefore counts cycles from the edge that commits the 7Fh write and requires the pulse to land inside the 3 to POLL_N+6 window. It also checks that outputs keep their values for several cycles after the pulse.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
   typedef enum logic [1:0] {
      BM_EXT      = 2'b00,
      BM_HOST     = 2'b01,
      BM_SERIAL   = 2'b10,
      BM_PARALLEL = 2'b11
   } boot_mode_e;

   typedef enum logic [3:0] {
      ST_SYNC,
      ST_STRAP,
      ST_PRIO,
      ST_CLR_PG,
      ST_CLR_PC,
      ST_WAIT,
      ST_RD_PC,
      ST_CHK_PC,
      ST_CHK_PG,
      ST_DONE
   } bsel_state_e;
endpackage

// File: rtl/bsel_sync.sv
module bsel_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/bsel_mbox.sv
module bsel_mbox #(
   parameter int AW = 7,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [DW-1:0] host_wdata,
   input  logic          loc_we,
   input  logic          loc_re,
   input  logic [AW-1:0] loc_addr,
   input  logic [DW-1:0] loc_wdata,
   output logic [DW-1:0] loc_rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic          clash;

   // local clear wins over a host write to the same word in the same cycle
   assign clash = loc_we && (loc_addr == host_addr);

   always_ff @(posedge clk) begin
      if (host_we && !clash) mem[host_addr] <= host_wdata;
      if (loc_we)            mem[loc_addr]  <= loc_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      loc_rdata <= '0;
      else if (loc_re) loc_rdata <= mem[loc_addr];
   end
endmodule

// File: rtl/bsel_ctrl.sv
module bsel_ctrl
   import boot_sel_pkg::*;
#(
   parameter int          AW        = 7,
   parameter int          DW        = 16,
   parameter int          XPC_W     = 7,
   parameter int          POLL_N    = 8,
   parameter int          SYNC_N    = 2,
   parameter logic [DW-1:0] VEC       = 16'hFF80,
   parameter logic [DW-1:0] EXT_ENTRY = 16'h0100,
   parameter logic [AW-1:0] PG_ADDR   = 7'h7E,
   parameter logic [AW-1:0] PC_ADDR   = 7'h7F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_s,
   input  logic             int2_s,
   input  logic             int3_s,
   input  logic [DW-1:0]    rd_data,
   output logic             loc_we,
   output logic             loc_re,
   output logic [AW-1:0]    loc_addr,
   output logic [DW-1:0]    loc_wdata,
   output logic             hint_n,
   output boot_mode_e       mode,
   output logic [DW-1:0]    pc,
   output logic [XPC_W-1:0] xpc,
   output logic             go
);
   localparam int CMAX = (POLL_N > SYNC_N) ? POLL_N : SYNC_N;
   localparam int CW   = $clog2(CMAX + 1);

   bsel_state_e   st;
   logic [CW-1:0] cnt;
   logic [DW-1:0] pc_hold;
   logic          pc_hit;

   assign pc_hit    = (st == ST_CHK_PC) && (rd_data != '0);
   assign loc_we    = (st == ST_CLR_PG) || (st == ST_CLR_PC);
   assign loc_re    = (st == ST_RD_PC) || pc_hit;
   assign loc_addr  = ((st == ST_CLR_PG) || (st == ST_CHK_PC)) ? PG_ADDR : PC_ADDR;
   assign loc_wdata = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_SYNC;
         cnt     <= '0;
         hint_n  <= 1'b1;
         mode    <= BM_EXT;
         pc      <= '0;
         xpc     <= '0;
         go      <= 1'b0;
         pc_hold <= '0;
      end else begin
         go <= 1'b0;
         case (st)
            ST_SYNC: begin
               if (cnt == CW'(SYNC_N - 1)) begin
                  cnt <= '0;
                  st  <= ST_STRAP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STRAP: begin
               if (strap_s) begin
                  mode <= BM_EXT;
                  pc   <= EXT_ENTRY;
                  go   <= 1'b1;
                  st   <= ST_DONE;
               end else begin
                  hint_n <= 1'b0;
                  pc     <= VEC;
                  st     <= ST_PRIO;
               end
            end
            ST_PRIO: begin
               if (!int2_s) begin
                  mode <= BM_HOST;
                  st   <= ST_CLR_PG;
               end else if (!int3_s) begin
                  mode <= BM_SERIAL;
                  go   <= 1'b1;
                  st   <= ST_DONE;
               end else begin
                  mode <= BM_PARALLEL;
                  go   <= 1'b1;
                  st   <= ST_DONE;
               end
            end
            ST_CLR_PG: st <= ST_CLR_PC;
            ST_CLR_PC: begin
               cnt <= '0;
               st  <= ST_WAIT;
            end
            ST_WAIT: begin
               if (cnt == CW'(POLL_N - 1)) begin
                  cnt <= '0;
                  st  <= ST_RD_PC;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RD_PC: st <= ST_CHK_PC;
            ST_CHK_PC: begin
               if (pc_hit) begin
                  pc_hold <= rd_data;
                  st      <= ST_CHK_PG;
               end else begin
                  st <= ST_WAIT;
               end
            end
            ST_CHK_PG: begin
               pc  <= pc_hold;
               xpc <= rd_data[XPC_W-1:0];
               go  <= 1'b1;
               st  <= ST_DONE;
            end
            ST_DONE: st <= ST_DONE;
            default: st <= ST_SYNC;
         endcase
      end
   end
endmodule

// File: rtl/boot_src_fsm.sv
module boot_src_fsm
   import boot_sel_pkg::*;
#(
   parameter int          AW        = 7,
   parameter int          DW        = 16,
   parameter int          XPC_W     = 7,
   parameter int          POLL_N    = 8,
   parameter int          SYNC_N    = 2,
   parameter logic [DW-1:0] VEC       = 16'hFF80,
   parameter logic [DW-1:0] EXT_ENTRY = 16'h0100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_ext,
   input  logic             int2_n,
   input  logic             int3_n,
   input  logic             host_we,
   input  logic [AW-1:0]    host_addr,
   input  logic [DW-1:0]    host_wdata,
   output logic             hint_n,
   output logic [1:0]       boot_mode,
   output logic [DW-1:0]    boot_pc,
   output logic [XPC_W-1:0] boot_xpc,
   output logic             boot_go
);
   localparam logic [AW-1:0] PG_ADDR = AW'(7'h7E);
   localparam logic [AW-1:0] PC_ADDR = AW'(7'h7F);

   generate
      if (AW < 7)                       begin : g_bad_aw  $error("AW must reach word 7Fh"); end
      if (POLL_N < 1)                   begin : g_bad_pol $error("POLL_N must be at least 1"); end
      if (SYNC_N < 2)                   begin : g_bad_syn $error("SYNC_N must be at least 2"); end
      if (XPC_W < 1 || XPC_W > DW)      begin : g_bad_xpc $error("XPC_W out of range"); end
   endgenerate

   logic [2:0]    raw_in, syn_in;
   logic          loc_we, loc_re;
   logic [AW-1:0] loc_addr;
   logic [DW-1:0] loc_wdata, loc_rdata;
   logic          poll_rd;
   boot_mode_e    mode;

   assign raw_in = {strap_ext, int2_n, int3_n};

   bsel_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b111)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );

   bsel_mbox #(.AW(AW), .DW(DW)) u_mbox (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .loc_we(loc_we), .loc_re(loc_re), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
   );

   bsel_ctrl #(
      .AW(AW), .DW(DW), .XPC_W(XPC_W), .POLL_N(POLL_N), .SYNC_N(SYNC_N),
      .VEC(VEC), .EXT_ENTRY(EXT_ENTRY), .PG_ADDR(PG_ADDR), .PC_ADDR(PC_ADDR)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .strap_s(syn_in[2]), .int2_s(syn_in[1]), .int3_s(syn_in[0]),
      .rd_data(loc_rdata),
      .loc_we(loc_we), .loc_re(loc_re), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
      .hint_n(hint_n), .mode(mode), .pc(boot_pc), .xpc(boot_xpc), .go(boot_go)
   );

   assign boot_mode = mode;
   assign poll_rd   = loc_re && (loc_addr == PC_ADDR);
endmodule

// File: rtl/bsel_chk.sv
module bsel_chk #(
   parameter int          DW        = 16,
   parameter int          POLL_N    = 8,
   parameter logic [DW-1:0] VEC       = 16'hFF80,
   parameter logic [DW-1:0] EXT_ENTRY = 16'h0100
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hint_n,
   input logic [1:0]    boot_mode,
   input logic [DW-1:0] boot_pc,
   input logic          boot_go,
   input logic          poll_rd
);
   localparam int GW = $clog2(POLL_N + 1);
   logic [GW-1:0] gap;
   logic          gone;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= GW'(POLL_N);
         gone <= 1'b0;
      end else begin
         if (poll_rd)                 gap <= '0;
         else if (gap < GW'(POLL_N))  gap <= gap + 1'b1;
         if (boot_go)                 gone <= 1'b1;
      end
   end

   a_r3_ext_keeps_hint: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_go && boot_mode == 2'b00) |-> (hint_n && boot_pc == EXT_ENTRY));
   a_r4_hint_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
      !hint_n |=> !hint_n);
   a_r5_loader_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_go && boot_mode[1]) |-> (!hint_n && boot_pc == VEC));
   a_r7_host_target_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_go && boot_mode == 2'b01) |-> (boot_pc != '0 && !hint_n));
   a_r9_single_go: assert property (@(posedge clk) disable iff (!rst_n)
      boot_go |=> !boot_go);
   a_r9_no_second_go: assert property (@(posedge clk) disable iff (!rst_n)
      gone |-> !boot_go);
   a_r9_hold_after_go: assert property (@(posedge clk) disable iff (!rst_n)
      gone |=> ($stable(boot_pc) && $stable(boot_mode)));
   a_r10_poll_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      poll_rd |-> (gap >= GW'(POLL_N)));
endmodule

bind boot_src_fsm bsel_chk #(
   .DW(DW), .POLL_N(POLL_N), .VEC(VEC), .EXT_ENTRY(EXT_ENTRY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hint_n(hint_n), .boot_mode(boot_mode),
   .boot_pc(boot_pc), .boot_go(boot_go), .poll_rd(poll_rd)
);

// File: tb/boot_src_fsm_tb.sv
module boot_src_fsm_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 7, DW = 16, XW = 7, POLL_N = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strap_ext = 1'b1, int2_n = 1'b1, int3_n = 1'b1;
   logic          host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0;
   logic          hint_n, boot_go;
   logic [1:0]    boot_mode;
   logic [DW-1:0] boot_pc;
   logic [XW-1:0] boot_xpc;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   boot_src_fsm u_dut (
      .clk(clk), .rst_n(rst_n), .strap_ext(strap_ext), .int2_n(int2_n), .int3_n(int3_n),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .hint_n(hint_n), .boot_mode(boot_mode), .boot_pc(boot_pc),
      .boot_xpc(boot_xpc), .boot_go(boot_go)
   );

   // {strap, int2_n, int3_n, mode[1:0], go edge[2:0]} ; go edge 0 = no pulse yet
   localparam logic [7:0] VECS [6] = '{
      {3'b111, 2'b00, 3'd3},
      {3'b100, 2'b00, 3'd3},
      {3'b010, 2'b10, 3'd4},
      {3'b011, 2'b11, 3'd4},
      {3'b000, 2'b01, 3'd0},
      {3'b001, 2'b01, 3'd0}
   };

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic s, input logic i2, input logic i3);
      @(negedge clk);
      rst_n = 1'b0;
      strap_ext = s; int2_n = i2; int3_n = i3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int go_cnt, go_at, lat;
      logic [1:0] mode_at;
      logic [DW-1:0] pc_at;

      // R1 reset state
      repeat (2) @(negedge clk);
      chk(hint_n == 1'b1, "R1 hint", 32'(hint_n), 1);
      chk(boot_go == 1'b0, "R1 go", 32'(boot_go), 0);
      chk(boot_mode == 2'b00, "R1 mode", 32'(boot_mode), 0);
      chk(boot_pc == 16'h0000, "R1 pc", 32'(boot_pc), 0);

      // table walk: R2 R3 R4 R5
      for (int v = 0; v < 6; v++) begin
         do_reset(VECS[v][7], VECS[v][6], VECS[v][5]);
         go_cnt = 0; go_at = 0; mode_at = 2'b00; pc_at = '0;
         for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (boot_go) begin
               go_cnt++; go_at = c; mode_at = boot_mode; pc_at = boot_pc;
            end
            if (c == 2) chk(boot_go == 1'b0 && hint_n == 1'b1, "R2 nothing before edge 3", 32'({boot_go, hint_n}), 1);
         end
         if (VECS[v][2:0] != 3'd0) begin
            chk(go_at == int'(VECS[v][2:0]), "R2 go edge", 32'(go_at), 32'(VECS[v][2:0]));
            chk(go_cnt == 1, "R9 one pulse", 32'(go_cnt), 1);
            chk(mode_at == VECS[v][4:3], "R5 mode", 32'(mode_at), 32'(VECS[v][4:3]));
            if (VECS[v][7]) begin
               chk(hint_n == 1'b1, "R3 hint high", 32'(hint_n), 1);
               chk(pc_at == 16'h0100, "R3 ext entry", 32'(pc_at), 32'h0100);
            end else begin
               chk(hint_n == 1'b0, "R4 hint low", 32'(hint_n), 0);
               chk(pc_at == 16'hFF80, "R4 vector", 32'(pc_at), 32'hFF80);
            end
         end else begin
            chk(go_cnt == 0, "R7 no go in host mode", 32'(go_cnt), 0);
            chk(boot_mode == 2'b01, "R5 host priority", 32'(boot_mode), 1);
            chk(hint_n == 1'b0 && boot_pc == 16'hFF80, "R4 host vector", 32'(boot_pc), 32'hFF80);
         end
      end

      // host-port boot with stale mailbox: R6 R7 R8 R9 R10
      @(negedge clk);
      rst_n = 1'b0; strap_ext = 1'b0; int2_n = 1'b0; int3_n = 1'b1;
      host_we = 1'b1; host_addr = 7'h7F; host_wdata = 16'h1234;
      @(negedge clk);
      host_addr = 7'h7E; host_wdata = 16'h0033;
      @(negedge clk);
      host_we = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      go_cnt = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (boot_go) go_cnt++;
      end
      chk(go_cnt == 0, "R6 stale 7Fh ignored", 32'(go_cnt), 0);

      host_write(7'h7E, 16'h0055);
      go_cnt = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (boot_go) go_cnt++;
      end
      chk(go_cnt == 0, "R7 page word alone", 32'(go_cnt), 0);

      @(negedge clk);
      host_we = 1'b1; host_addr = 7'h7F; host_wdata = 16'h8000;
      @(negedge clk);
      host_we = 1'b0;
      lat = 0; go_cnt = 0; go_at = 0;
      for (int k = 1; k <= 3 * POLL_N + 10; k++) begin
         if (k > 1) @(negedge clk);
         if (boot_go) begin
            go_cnt++;
            if (go_at == 0) begin
               go_at = k; pc_at = boot_pc; mode_at = boot_mode;
               chk(boot_xpc == 7'h55, "R8 page", 32'(boot_xpc), 32'h55);
            end
         end
      end
      lat = go_at;
      chk(lat >= 3 && lat <= POLL_N + 6, "R8 latency window", 32'(lat), POLL_N + 6);
      chk(lat >= 3, "R10 poll read precedes go", 32'(lat), 3);
      chk(pc_at == 16'h8000, "R8 target", 32'(pc_at), 32'h8000);
      chk(mode_at == 2'b01, "R8 mode", 32'(mode_at), 1);
      chk(go_cnt == 1, "R9 single pulse", 32'(go_cnt), 1);
      host_write(7'h7F, 16'h4444);
      repeat (POLL_N + 4) @(negedge clk);
      chk(boot_pc == 16'h8000 && boot_xpc == 7'h55 && !boot_go, "R9 hold", 32'(boot_pc), 32'h8000);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule